// File: doc/BRIEF.md
# Reorder Buffer with Speculative Flush

This block keeps in-flight instructions in program order while they execute out of order. Each instruction accepted at issue is given a slot in a circular buffer. The slot index is returned at once as the instruction's rename tag, and consumers use it to pick the result off the shared result bus. Finished results are parked in their slot. Nothing reaches architectural state until the slot becomes the oldest one.

The oldest slot retires when its result is present. A register-writing entry drives a register-file write port, and a store entry drives a store port. A branch leaves silently when it was predicted correctly. When the branch turns out to be mispredicted, every younger slot is discarded in one step, and a single-cycle flush pulse tells the front end to refetch.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `issueReady` is 1, `issueTag` is 0, and `commitRegWe`, `commitStoreWe` and `flushOut` are 0.
- R2: Accepted issues receive consecutive tags, and the tag wraps from DEPTH-1 to 0; `issueTag` shows the tag the current request will take.
- R3: With DEPTH entries outstanding, `issueReady` is 0 and an issue request is ignored: the tag does not advance and the instruction never commits. Draining one entry makes room again.
- R4: A completed entry does not commit while any older entry still lacks its result.
- R5: A register entry (`issueKind` 2'b00) at the head commits in the cycle after the edge that captured its result. It pulses `commitRegWe` for one cycle, with `commitRegAddr` set to its destination and `commitRegData` set to its result.
- R6: A store entry (`issueKind` 2'b01) at the head commits by pulsing `commitStoreWe` for one cycle with its result on `commitStoreData`. At most one of the commit strobes and `flushOut` is high in any cycle.
- R7: A branch entry (`issueKind` 2'b10) at the head blocks all younger commits until resolved. When its resolution carries `cdbMispredict`=0, it retires for one cycle with no strobe, and the next entry commits in the following cycle.
- R8: A branch resolved with `cdbMispredict`=1 raises `flushOut` for exactly one cycle once it is at the head. `issueReady` is 0 in that cycle. Afterwards the buffer is empty, no younger entry ever commits, and the next issue tag is the branch's slot plus one.
- R9: A result broadcast to a slot that holds no instruction is ignored. A later instruction allocated to that slot waits for its own result.
- R10: Entries commit in issue order even when their results arrive in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueKind | input | 2 | 00 register write, 01 store, 10 branch |
| issueDest | input | REG_W | Destination register of the request |
| issueReady | output | 1 | Slot available; request accepted this cycle |
| issueTag | output | IDX_W | Slot (rename tag) given to the request |
| cdbValid | input | 1 | Result bus valid |
| cdbTag | input | IDX_W | Slot the result belongs to |
| cdbValue | input | DATA_W | Result value |
| cdbMispredict | input | 1 | Branch resolved as mispredicted |
| commitRegWe | output | 1 | Register-file write strobe |
| commitRegAddr | output | REG_W | Register-file write address |
| commitRegData | output | DATA_W | Register-file write data |
| commitStoreWe | output | 1 | Store-port strobe |
| commitStoreData | output | DATA_W | Store data |
| flushOut | output | 1 | Mispredict squash pulse |

## Verification
`issueTag` and `issueReady` are combinational, so they are checked in the same cycle as the request. A result on the bus is captured at the next rising edge. The matching commit strobe, or the flush pulse for a mispredicted branch, appears in the cycle that follows that edge, provided the entry is at the head. Younger entries then follow one per cycle. The bench drives inputs and samples outputs at falling edges. It checks each strobe at the first falling edge after the capturing edge, then checks one falling edge later that the strobe has dropped or moved on to the next entry.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } robKind_e;

  typedef struct packed {
    logic doIssue;
    logic doCommit;
    logic doFlush;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             headValid,
  input  logic             headReady,
  input  robKind_e         headKind,
  input  logic             headMisp,
  output robStrobe_t       strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic             issueReady,
  output logic             regWe,
  output logic             storeWe
);
  logic [IDX_W:0] headPtr, tailPtr;
  logic full, retire, flush;

  assign headIdx = headPtr[IDX_W-1:0];
  assign tailIdx = tailPtr[IDX_W-1:0];
  assign full    = (headIdx == tailIdx) && (headPtr[IDX_W] != tailPtr[IDX_W]);

  assign retire     = headValid && headReady;
  assign flush      = retire && (headKind == KIND_BRANCH) && headMisp;
  assign issueReady = !full && !flush;

  assign strobe.doIssue  = issueValid && issueReady;
  assign strobe.doCommit = retire;
  assign strobe.doFlush  = flush;

  assign regWe   = retire && (headKind == KIND_REG);
  assign storeWe = retire && (headKind == KIND_STORE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (flush) begin
      headPtr <= headPtr + 1'b1;
      tailPtr <= headPtr + 1'b1;
    end else begin
      if (retire)         headPtr <= headPtr + 1'b1;
      if (strobe.doIssue) tailPtr <= tailPtr + 1'b1;
    end
  end
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobe_t        strobe,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  tailIdx,
  input  robKind_e          issueKind,
  input  logic [REG_W-1:0]  issueDest,
  input  logic              cdbValid,
  input  logic [IDX_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbValue,
  input  logic              cdbMispredict,
  output logic              headValid,
  output logic              headReady,
  output robKind_e          headKind,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headValue,
  output logic              headMisp
);
  logic [DEPTH-1:0] validQ, readyQ, mispQ;
  robKind_e          kindQ  [DEPTH];
  logic [REG_W-1:0]  destQ  [DEPTH];
  logic [DATA_W-1:0] valueQ [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      readyQ <= '0;
    end else if (strobe.doFlush) begin
      validQ <= '0;
      readyQ <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (strobe.doIssue && (tailIdx == IDX_W'(s))) begin
          validQ[s] <= 1'b1;
          readyQ[s] <= 1'b0;
          kindQ[s]  <= issueKind;
          destQ[s]  <= issueDest;
        end else if (cdbValid && (cdbTag == IDX_W'(s)) && validQ[s]) begin
          readyQ[s] <= 1'b1;
          valueQ[s] <= cdbValue;
          mispQ[s]  <= cdbMispredict;
        end
        if (strobe.doCommit && (headIdx == IDX_W'(s))) begin
          validQ[s] <= 1'b0;
          readyQ[s] <= 1'b0;
        end
      end
    end
  end

  assign headValid = validQ[headIdx];
  assign headReady = readyQ[headIdx];
  assign headKind  = kindQ[headIdx];
  assign headDest  = destQ[headIdx];
  assign headValue = valueQ[headIdx];
  assign headMisp  = mispQ[headIdx];
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueKind,
  input  logic [REG_W-1:0]  issueDest,
  output logic              issueReady,
  output logic [IDX_W-1:0]  issueTag,
  input  logic              cdbValid,
  input  logic [IDX_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbValue,
  input  logic              cdbMispredict,
  output logic              commitRegWe,
  output logic [REG_W-1:0]  commitRegAddr,
  output logic [DATA_W-1:0] commitRegData,
  output logic              commitStoreWe,
  output logic [DATA_W-1:0] commitStoreData,
  output logic              flushOut
);
  robStrobe_t        strobe;
  logic [IDX_W-1:0]  headIdx, tailIdx;
  logic              headValid, headReady, headMisp;
  robKind_e          headKind;
  logic [REG_W-1:0]  headDest;
  logic [DATA_W-1:0] headValue;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .headValid(headValid), .headReady(headReady), .headKind(headKind),
    .headMisp(headMisp), .strobe(strobe), .headIdx(headIdx),
    .tailIdx(tailIdx), .issueReady(issueReady),
    .regWe(commitRegWe), .storeWe(commitStoreWe)
  );

  rob_data #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx),
    .tailIdx(tailIdx), .issueKind(robKind_e'(issueKind)),
    .issueDest(issueDest), .cdbValid(cdbValid), .cdbTag(cdbTag),
    .cdbValue(cdbValue), .cdbMispredict(cdbMispredict),
    .headValid(headValid), .headReady(headReady), .headKind(headKind),
    .headDest(headDest), .headValue(headValue), .headMisp(headMisp)
  );

  assign issueTag        = tailIdx;
  assign commitRegAddr   = headDest;
  assign commitRegData   = headValue;
  assign commitStoreData = headValue;
  assign flushOut        = strobe.doFlush;
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic             issueReady,
  input logic [IDX_W-1:0] issueTag,
  input logic             commitRegWe,
  input logic             commitStoreWe,
  input logic             flushOut
);
  AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && issueReady |=> issueTag == $past(issueTag) + 1'b1); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    !issueReady && !flushOut |=> $stable(issueTag)); // R3
  AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commitRegWe, commitStoreWe, flushOut})); // R6
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> !flushOut); // R8
  AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> !commitRegWe && !commitStoreWe && issueReady); // R8
endmodule

bind rob_top rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .issueTag(issueTag), .commitRegWe(commitRegWe),
  .commitStoreWe(commitStoreWe), .flushOut(flushOut)
);

// File: tb/rob_top_tb.sv
`timescale 1ns/1ps
module rob_top_tb;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32, IDX_W = 3;
  localparam logic [1:0] K_REG = 2'b00, K_ST = 2'b01, K_BR = 2'b10;

  logic clk = 0, rstN = 0;
  logic issueValid = 0, cdbValid = 0, cdbMispredict = 0;
  logic [1:0] issueKind = K_REG;
  logic [REG_W-1:0] issueDest = '0;
  logic [IDX_W-1:0] cdbTag = '0;
  logic [DATA_W-1:0] cdbValue = '0;
  logic issueReady, commitRegWe, commitStoreWe, flushOut;
  logic [IDX_W-1:0] issueTag;
  logic [REG_W-1:0] commitRegAddr;
  logic [DATA_W-1:0] commitRegData, commitStoreData;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rob_top #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueKind(issueKind),
    .issueDest(issueDest), .issueReady(issueReady), .issueTag(issueTag),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbValue(cdbValue),
    .cdbMispredict(cdbMispredict), .commitRegWe(commitRegWe),
    .commitRegAddr(commitRegAddr), .commitRegData(commitRegData),
    .commitStoreWe(commitStoreWe), .commitStoreData(commitStoreData),
    .flushOut(flushOut)
  );

  task automatic chkEq(input string req, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doIssue(input logic [1:0] k, input int d, input int expTag, input string req);
    issueValid = 1; issueKind = k; issueDest = REG_W'(d);
    chkEq({req, " tag"}, issueTag, expTag);
    @(negedge clk);
    issueValid = 0;
  endtask

  task automatic doCdb(input int tag, input int val, input bit misp);
    cdbValid = 1; cdbTag = IDX_W'(tag); cdbValue = DATA_W'(val); cdbMispredict = misp;
    @(negedge clk);
    cdbValid = 0; cdbMispredict = 0;
  endtask

  task automatic tReset();
    chkEq("R1 ready", issueReady, 1);
    chkEq("R1 tag", issueTag, 0);
    chkEq("R1 regWe", commitRegWe, 0);
    chkEq("R1 storeWe", commitStoreWe, 0);
    chkEq("R1 flush", flushOut, 0);
  endtask

  task automatic tInOrder();
    doIssue(K_REG, 1, 0, "R2");
    doIssue(K_REG, 2, 1, "R2");
    doIssue(K_REG, 3, 2, "R2");
    doCdb(2, 'h33, 0);
    chkEq("R4 younger done", commitRegWe, 0);
    doCdb(1, 'h22, 0);
    chkEq("R4 younger done", commitRegWe, 0);
    doCdb(0, 'h11, 0);
    chkEq("R5 regWe", commitRegWe, 1);
    chkEq("R5 addr", commitRegAddr, 1);
    chkEq("R5 data", commitRegData, 'h11);
    @(negedge clk);
    chkEq("R10 addr2", commitRegAddr, 2);
    chkEq("R10 data2", commitRegData, 'h22);
    @(negedge clk);
    chkEq("R10 addr3", commitRegAddr, 3);
    chkEq("R10 we3", commitRegWe, 1);
    @(negedge clk);
    chkEq("R5 pulse ends", commitRegWe, 0);
  endtask

  task automatic tStore();
    doIssue(K_ST, 0, 3, "R2");
    doCdb(3, 'h55, 0);
    chkEq("R6 storeWe", commitStoreWe, 1);
    chkEq("R6 data", commitStoreData, 'h55);
    chkEq("R6 regWe", commitRegWe, 0);
    @(negedge clk);
    chkEq("R6 pulse ends", commitStoreWe, 0);
  endtask

  task automatic tBranchOk();
    doIssue(K_BR, 0, 4, "R2");
    doIssue(K_REG, 7, 5, "R2");
    doCdb(5, 'h77, 0);
    chkEq("R7 blocked", commitRegWe, 0);
    @(negedge clk);
    chkEq("R7 still blocked", commitRegWe, 0);
    doCdb(4, 0, 0);
    chkEq("R7 branch silent reg", commitRegWe, 0);
    chkEq("R7 branch silent flush", flushOut, 0);
    @(negedge clk);
    chkEq("R7 next commits", commitRegWe, 1);
    chkEq("R7 next addr", commitRegAddr, 7);
    chkEq("R7 next data", commitRegData, 'h77);
    @(negedge clk);
  endtask

  task automatic tBranchBad();
    doIssue(K_BR, 0, 6, "R2");
    doIssue(K_REG, 8, 7, "R2");
    doIssue(K_ST, 0, 0, "R2 wrap");
    doCdb(7, 'h88, 0);
    doCdb(0, 'h99, 0);
    doCdb(6, 0, 1);
    chkEq("R8 flush", flushOut, 1);
    chkEq("R8 ready low", issueReady, 0);
    chkEq("R8 no reg", commitRegWe, 0);
    @(negedge clk);
    chkEq("R8 flush once", flushOut, 0);
    chkEq("R8 squashed reg", commitRegWe, 0);
    chkEq("R8 squashed store", commitStoreWe, 0);
    chkEq("R8 ready", issueReady, 1);
    chkEq("R8 next tag", issueTag, 7);
    @(negedge clk);
    chkEq("R8 stays empty", commitRegWe | commitStoreWe, 0);
  endtask

  task automatic tStrayCdb();
    doCdb(7, 'h99, 0);
    doIssue(K_REG, 9, 7, "R9");
    chkEq("R9 not ready", commitRegWe, 0);
    @(negedge clk);
    chkEq("R9 still waiting", commitRegWe, 0);
    doCdb(7, 'h42, 0);
    chkEq("R9 own result", commitRegWe, 1);
    chkEq("R9 addr", commitRegAddr, 9);
    chkEq("R9 data", commitRegData, 'h42);
    @(negedge clk);
  endtask

  task automatic tFull();
    for (int i = 0; i < DEPTH; i++) doIssue(K_REG, 10 + i, i, "R3");
    chkEq("R3 full", issueReady, 0);
    issueValid = 1; issueDest = 30; issueKind = K_REG;
    @(negedge clk);
    issueValid = 0;
    chkEq("R3 tag held", issueTag, 0);
    chkEq("R3 still full", issueReady, 0);
    for (int i = 0; i < DEPTH; i++) begin
      doCdb(i, 200 + i, 0);
      chkEq("R3 drain we", commitRegWe, 1);
      chkEq("R3 drain addr", commitRegAddr, 10 + i);
      chkEq("R3 drain data", commitRegData, 200 + i);
    end
    @(negedge clk);
    chkEq("R3 dropped request", commitRegWe, 0);
    chkEq("R3 room again", issueReady, 1);
    chkEq("R3 tag", issueTag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tInOrder();
    tStore();
    tBranchOk();
    tBranchBad();
    tStrayCdb();
    tFull();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule